// File: doc/BRIEF.md
# NAND DMA Command Intake Filter

This block sits between a host register port and a NAND flash controller core. Each host write is a command-data pair. The command carries a 2-bit MAP class, a 2-bit sub-operation and a 2-bit pair index, and the data word is the payload. The block routes every pair to one of three places:

- Pairs that make up a multi-transaction data DMA command are gathered into a descriptor and queued for a DMA engine.
- Commands that the flash core may execute are passed straight through to it.
- Anything illegal in the present mode or sequence state is dropped, and a one-cycle unsupported-command interrupt is raised.

A data DMA command is four pairs that must arrive in index order 0, 1, 2, 3:

| Index | Payload |
|-------|---------|
| 0 | Start page and transfer direction |
| 1 | Page count |
| 2 | Upper half of the host address |
| 3 | Lower half of the host address |

The descriptor is built only when index 3 arrives, and only if the transfer stays inside one flash erase block and fewer than the allowed number of descriptors are outstanding. The outstanding count rises with each queued descriptor and falls with each completion pulse from the DMA engine.

Top module: `nand_dma_intake`

## Requirements
- R1: With `dma_en` low, MAP classes 00, 01 and 11 are passed to the forward port with map, op and data unchanged, and a MAP 10 op 00 (data DMA) pair is rejected.
- R2: With `dma_en` high, MAP classes 00, 01 and 11 are rejected and never appear on the forward port.
- R3: MAP 10 with op 10 or 11 (erase, lock, unlock and copy-back family) is forwarded in either mode when no DMA sequence is open. MAP 10 with op 01 (pipeline read/write) is always rejected.
- R4: Four in-order data DMA pairs with indices 0..3 produce one descriptor, visible the cycle after index 3 is accepted. The descriptor fields are taken as follows:
  - direction from pair 0 bit 31;
  - start page from pair 0 bits 23:0;
  - page count from pair 1 bits 15:0;
  - host address as {pair 2, pair 3}.
- R5: A data DMA pair whose index is not the expected one (index 0 when idle, otherwise the next index) is rejected, any partial sequence is discarded, and the next sequence must start at index 0.
- R6: Any non-DMA command that arrives while a sequence is open is rejected and not forwarded, and the partial sequence is discarded.
- R7: At index 3, if (start page mod PAGES_PER_BLK) + count > PAGES_PER_BLK, the command is rejected and no descriptor is made. A sum exactly equal to PAGES_PER_BLK is accepted.
- R8: At most MAX_OUT (4) descriptors are outstanding. A further complete command is rejected. Each `dma_done` pulse frees one slot, and a pulse while nothing is outstanding has no effect.
- R9: `unsup_irq` is high for exactly the cycle after each rejected pair is accepted, and it is low in every other cycle.
- R10: Pairs that are rejected or consumed by the DMA path are accepted at once (`cmd_ready` high). A forwarded command waits for `fwd_ready`.
- R11: Reset, whether at start-up or in mid-run, clears the open sequence, the descriptor queue, the outstanding count and the interrupt.
- R12: Descriptors leave in the order they were built, and they stay stable while `desc_valid` is high and `desc_ready` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dma_en | input | 1 | DMA mode enable level |
| cmd_valid | input | 1 | Command-data pair present |
| cmd_ready | output | 1 | Pair taken this cycle |
| cmd_map | input | 2 | MAP class of the command |
| cmd_op | input | 2 | Sub-operation within MAP 10 |
| cmd_seq | input | 2 | Pair index of a data DMA command |
| cmd_data | input | DATA_W | Pair payload |
| fwd_valid | output | 1 | Command offered to the flash core |
| fwd_ready | input | 1 | Flash core takes the command |
| fwd_map | output | 2 | Forwarded MAP class |
| fwd_op | output | 2 | Forwarded sub-operation |
| fwd_data | output | DATA_W | Forwarded payload |
| desc_valid | output | 1 | Descriptor at queue head |
| desc_ready | input | 1 | DMA engine takes the descriptor |
| desc_dir | output | 1 | Transfer direction |
| desc_page | output | PAGE_W | Start page |
| desc_count | output | CNT_W | Page count |
| desc_addr | output | 2*DATA_W | Host address |
| dma_done | input | 1 | One descriptor finished |
| unsup_irq | output | 1 | Unsupported-command pulse |

## Verification
The bench targets the following corner cases:
- **Skipped or repeated index.** The sequence is broken by a skipped or repeated index, and by a stray index 1 while idle. A design that resumed from the wrong index would emit a descriptor built from mixed pairs.
- **Interleaved command.** A maintenance command is slipped into an open sequence. Leaking it to the flash core, or keeping the partial pairs, both show up on the ports.
- **Block boundary edges.** Transfers end exactly on a block boundary and one page past it. An off-by-one in the comparison rejects the first or admits the second.
- **Outstanding limit.** The limit is filled, a fifth command is refused, and completion pulses arrive while nothing is outstanding. A counter that wraps or misses the limit would queue too many descriptors.

// File: rtl/nand_intake_pkg.sv
package nand_intake_pkg;

   typedef enum logic [1:0] {
      MAP_00 = 2'b00,
      MAP_01 = 2'b01,
      MAP_10 = 2'b10,
      MAP_11 = 2'b11
   } map_e;

   typedef enum logic [1:0] {
      OP_DATA_DMA = 2'b00,
      OP_PIPELINE = 2'b01,
      OP_MAINT_A  = 2'b10,
      OP_MAINT_B  = 2'b11
   } op_e;

   typedef enum logic [1:0] {
      IDX_PAGE    = 2'd0,
      IDX_COUNT   = 2'd1,
      IDX_ADDR_HI = 2'd2,
      IDX_ADDR_LO = 2'd3
   } pair_e;

endpackage

// File: rtl/nand_intake_classify.sv
module nand_intake_classify
   import nand_intake_pkg::*;
(
   input  logic       dma_en,
   input  logic [1:0] map,
   input  logic [1:0] op,
   output logic       is_dma,
   output logic       is_fwd,
   output logic       is_bad
);

   always_comb begin
      is_dma = 1'b0;
      is_bad = 1'b0;
      if (map != MAP_10) begin
         is_bad = dma_en;
      end else begin
         case (op)
            OP_DATA_DMA: begin
               is_dma = dma_en;
               is_bad = !dma_en;
            end
            OP_PIPELINE: is_bad = 1'b1;
            default:     is_bad = 1'b0;
         endcase
      end
      is_fwd = !is_dma && !is_bad;
   end

endmodule

// File: rtl/nand_intake_seq.sv
module nand_intake_seq
   import nand_intake_pkg::*;
#(
   parameter int DATA_W        = 32,
   parameter int PAGE_W        = 24,
   parameter int CNT_W         = 16,
   parameter int PAGES_PER_BLK = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                fire,
   input  logic                is_dma,
   input  logic [1:0]          idx,
   input  logic [DATA_W-1:0]   data,
   input  logic                q_full,
   output logic                mid,
   output logic                err,
   output logic                push,
   output logic                o_dir,
   output logic [PAGE_W-1:0]   o_page,
   output logic [CNT_W-1:0]    o_cnt,
   output logic [2*DATA_W-1:0] o_addr
);

   localparam int OFF_W = $clog2(PAGES_PER_BLK);
   localparam int SUM_W = ((CNT_W > OFF_W) ? CNT_W : OFF_W) + 1;

   logic [1:0]        exp_q;
   logic              st_dir;
   logic [PAGE_W-1:0] st_page;
   logic [CNT_W-1:0]  st_cnt;
   logic [DATA_W-1:0] st_hi;

   logic             in_order, last, crosses;
   logic [SUM_W-1:0] span_end;

   always_comb begin
      mid      = (exp_q != IDX_PAGE);
      in_order = is_dma && (idx == exp_q);
      last     = fire && in_order && (idx == IDX_ADDR_LO);
      span_end = SUM_W'(st_page[OFF_W-1:0]) + SUM_W'(st_cnt);
      crosses  = span_end > SUM_W'(PAGES_PER_BLK);
      push     = last && !crosses && !q_full;
      err      = fire && ((is_dma && !in_order) || (!is_dma && mid) ||
                          (last && (crosses || q_full)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp_q   <= IDX_PAGE;
         st_dir  <= 1'b0;
         st_page <= '0;
         st_cnt  <= '0;
         st_hi   <= '0;
      end else if (fire) begin
         if (in_order) begin
            case (idx)
               IDX_PAGE: begin
                  st_dir  <= data[DATA_W-1];
                  st_page <= data[PAGE_W-1:0];
               end
               IDX_COUNT:   st_cnt <= data[CNT_W-1:0];
               IDX_ADDR_HI: st_hi  <= data;
               default:     st_hi  <= st_hi;
            endcase
            exp_q <= idx + 2'd1;
         end else begin
            exp_q <= IDX_PAGE;
         end
      end
   end

   assign o_dir  = st_dir;
   assign o_page = st_page;
   assign o_cnt  = st_cnt;
   assign o_addr = {st_hi, data};

endmodule

// File: rtl/nand_intake_queue.sv
module nand_intake_queue #(
   parameter int W     = 105,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         rd_ready,
   input  logic         done,
   output logic         rd_valid,
   output logic [W-1:0] rdata,
   output logic         full
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int LVL_W = $clog2(DEPTH + 1);

   logic [W-1:0]     slot [DEPTH];
   logic [PTR_W-1:0] wr_q, rd_q;
   logic [LVL_W-1:0] level_q, outst_q;
   logic             pop, retire;

   function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
   endfunction

   assign rd_valid = (level_q != '0);
   assign pop      = rd_valid && rd_ready;
   assign retire   = done && (outst_q != '0);
   assign full     = (outst_q == LVL_W'(DEPTH)) || (level_q == LVL_W'(DEPTH));
   assign rdata    = slot[rd_q];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (push && (wr_q == PTR_W'(i))) slot[i] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q    <= '0;
         rd_q    <= '0;
         level_q <= '0;
         outst_q <= '0;
      end else begin
         if (push) wr_q <= step(wr_q);
         if (pop)  rd_q <= step(rd_q);
         level_q <= level_q + LVL_W'(push) - LVL_W'(pop);
         outst_q <= outst_q + LVL_W'(push) - LVL_W'(retire);
      end
   end

endmodule

// File: rtl/nand_dma_intake.sv
module nand_dma_intake
   import nand_intake_pkg::*;
#(
   parameter int DATA_W        = 32,
   parameter int PAGE_W        = 24,
   parameter int CNT_W         = 16,
   parameter int PAGES_PER_BLK = 64,
   parameter int MAX_OUT       = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                dma_en,
   input  logic                cmd_valid,
   output logic                cmd_ready,
   input  logic [1:0]          cmd_map,
   input  logic [1:0]          cmd_op,
   input  logic [1:0]          cmd_seq,
   input  logic [DATA_W-1:0]   cmd_data,
   output logic                fwd_valid,
   input  logic                fwd_ready,
   output logic [1:0]          fwd_map,
   output logic [1:0]          fwd_op,
   output logic [DATA_W-1:0]   fwd_data,
   output logic                desc_valid,
   input  logic                desc_ready,
   output logic                desc_dir,
   output logic [PAGE_W-1:0]   desc_page,
   output logic [CNT_W-1:0]    desc_count,
   output logic [2*DATA_W-1:0] desc_addr,
   input  logic                dma_done,
   output logic                unsup_irq
);

   localparam int ADDR_W = 2 * DATA_W;
   localparam int DESC_W = 1 + PAGE_W + CNT_W + ADDR_W;

   if (PAGE_W >= DATA_W || CNT_W > DATA_W) begin : g_bad_width
      $error("page field must leave the direction bit free and count must fit the payload");
   end
   if (PAGES_PER_BLK < 2 || (PAGES_PER_BLK & (PAGES_PER_BLK - 1)) != 0) begin : g_bad_blk
      $error("PAGES_PER_BLK must be a power of two of at least 2");
   end
   if (MAX_OUT < 1) begin : g_bad_depth
      $error("MAX_OUT must be at least 1");
   end

   logic              is_dma, is_fwd, is_bad;
   logic              mid, seq_err, push, q_full, fwd_go, fire, irq_q;
   logic              s_dir;
   logic [PAGE_W-1:0] s_page;
   logic [CNT_W-1:0]  s_cnt;
   logic [ADDR_W-1:0] s_addr;
   logic [DESC_W-1:0] head;

   nand_intake_classify u_cls (
      .dma_en (dma_en),
      .map    (cmd_map),
      .op     (cmd_op),
      .is_dma (is_dma),
      .is_fwd (is_fwd),
      .is_bad (is_bad)
   );

   assign fwd_go    = is_fwd && !mid;
   assign cmd_ready = fwd_go ? fwd_ready : 1'b1;
   assign fire      = cmd_valid && cmd_ready;
   assign fwd_valid = cmd_valid && fwd_go;
   assign fwd_map   = cmd_map;
   assign fwd_op    = cmd_op;
   assign fwd_data  = cmd_data;

   nand_intake_seq #(
      .DATA_W        (DATA_W),
      .PAGE_W        (PAGE_W),
      .CNT_W         (CNT_W),
      .PAGES_PER_BLK (PAGES_PER_BLK)
   ) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire   (fire),
      .is_dma (is_dma),
      .idx    (cmd_seq),
      .data   (cmd_data),
      .q_full (q_full),
      .mid    (mid),
      .err    (seq_err),
      .push   (push),
      .o_dir  (s_dir),
      .o_page (s_page),
      .o_cnt  (s_cnt),
      .o_addr (s_addr)
   );

   nand_intake_queue #(
      .W     (DESC_W),
      .DEPTH (MAX_OUT)
   ) u_q (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (push),
      .wdata    ({s_dir, s_page, s_cnt, s_addr}),
      .rd_ready (desc_ready),
      .done     (dma_done),
      .rd_valid (desc_valid),
      .rdata    (head),
      .full     (q_full)
   );

   assign {desc_dir, desc_page, desc_count, desc_addr} = head;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= seq_err || (fire && is_bad);
   end

   assign unsup_irq = irq_q;

endmodule

// File: rtl/nand_dma_intake_chk.sv
module nand_dma_intake_chk #(
   parameter int DESC_W = 105
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dma_en,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic [1:0]        cmd_map,
   input logic [1:0]        cmd_op,
   input logic [1:0]        cmd_seq,
   input logic              fwd_valid,
   input logic              desc_valid,
   input logic              desc_ready,
   input logic [DESC_W-1:0] desc_word,
   input logic              unsup_irq
);

   p_no_fwd_when_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_en && fwd_valid) |-> (cmd_map == 2'b10));

   p_no_fwd_dma_pipe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |-> !(cmd_map == 2'b10 && (cmd_op == 2'b00 || cmd_op == 2'b01)));

   p_desc_from_last_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(desc_valid) |-> $past(cmd_valid && cmd_ready && cmd_map == 2'b10 &&
                                  cmd_op == 2'b00 && cmd_seq == 2'b11));

   p_irq_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      unsup_irq |-> $past(cmd_valid && cmd_ready));

   p_ready_unless_fwd_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !fwd_valid) |-> cmd_ready);

   p_desc_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_valid && !desc_ready) |=> (desc_valid && $stable(desc_word)));

endmodule

bind nand_dma_intake nand_dma_intake_chk #(
   .DESC_W (1 + PAGE_W + CNT_W + 2 * DATA_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .dma_en     (dma_en),
   .cmd_valid  (cmd_valid),
   .cmd_ready  (cmd_ready),
   .cmd_map    (cmd_map),
   .cmd_op     (cmd_op),
   .cmd_seq    (cmd_seq),
   .fwd_valid  (fwd_valid),
   .desc_valid (desc_valid),
   .desc_ready (desc_ready),
   .desc_word  ({desc_dir, desc_page, desc_count, desc_addr}),
   .unsup_irq  (unsup_irq)
);

// File: tb/nand_dma_intake_bench.sv
`timescale 1ns/1ps
module nand_dma_intake_bench;

   localparam int DW = 1 + 24 + 16 + 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dma_en = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [1:0]  cmd_map = '0, cmd_op = '0, cmd_seq = '0;
   logic [31:0] cmd_data = '0;
   logic        fwd_valid, fwd_ready = 1'b1;
   logic [1:0]  fwd_map, fwd_op;
   logic [31:0] fwd_data;
   logic        desc_valid, desc_ready = 1'b0, desc_dir;
   logic [23:0] desc_page;
   logic [15:0] desc_count;
   logic [63:0] desc_addr;
   logic        dma_done = 1'b0;
   logic        unsup_irq;

   always #2 clk = ~clk;

   nand_dma_intake u_nand_dma_intake (
      .clk(clk), .rst_n(rst_n), .dma_en(dma_en),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_map(cmd_map),
      .cmd_op(cmd_op), .cmd_seq(cmd_seq), .cmd_data(cmd_data),
      .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_map(fwd_map),
      .fwd_op(fwd_op), .fwd_data(fwd_data),
      .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_dir(desc_dir),
      .desc_page(desc_page), .desc_count(desc_count), .desc_addr(desc_addr),
      .dma_done(dma_done), .unsup_irq(unsup_irq)
   );

   int n_chk = 0;
   int n_fail = 0;

   // behavioural reference state
   int            m_exp = 0;
   int            m_out = 0;
   bit            m_irq = 1'b0;
   bit            m_dir;
   int            m_page, m_cnt;
   logic [31:0]   m_hi;
   logic [DW-1:0] m_q[$];

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_exp = 0; m_out = 0; m_irq = 1'b0;
      m_q.delete();
   endtask

   // one clock: drive at negedge, compare, advance model across the posedge
   task automatic cyc(input bit v, input logic [1:0] map, input logic [1:0] op,
                      input logic [1:0] idx, input logic [31:0] data, input string tag);
      bit is_dma, is_bad, is_fwd, mid, go, rdy, fire, nirq, full, push;
      logic [DW-1:0] nd;
      cmd_valid = v; cmd_map = map; cmd_op = op; cmd_seq = idx; cmd_data = data;
      #1;
      is_dma = (map == 2'b10) && (op == 2'b00) && dma_en;
      is_bad = (map != 2'b10) ? dma_en : ((op == 2'b00) ? !dma_en : (op == 2'b01));
      is_fwd = !is_dma && !is_bad;
      mid    = (m_exp != 0);
      go     = is_fwd && !mid;
      rdy    = go ? fwd_ready : 1'b1;
      chk(cmd_ready == rdy, tag, "cmd_ready", cmd_ready, rdy);
      chk(fwd_valid == (v && go), tag, "fwd_valid", fwd_valid, v && go);
      if (v && go)
         chk({fwd_map, fwd_op, fwd_data} == {map, op, data}, tag, "fwd fields",
             {fwd_map, fwd_op, fwd_data}, {map, op, data});
      chk(unsup_irq == m_irq, tag, "unsup_irq", unsup_irq, m_irq);
      chk(desc_valid == (m_q.size() != 0), tag, "desc_valid", desc_valid, m_q.size() != 0);
      if (m_q.size() != 0)
         chk({desc_dir, desc_page, desc_count, desc_addr} == m_q[0], tag, "descriptor",
             {desc_dir, desc_page, desc_count, desc_addr}, m_q[0]);
      fire = v && rdy;
      nirq = 1'b0;
      push = 1'b0;
      full = (m_out >= 4) || (m_q.size() >= 4);
      if (fire) begin
         if (is_dma) begin
            if (int'(idx) == m_exp) begin
               case (idx)
                  2'd0: begin m_dir = data[31]; m_page = int'(data[23:0]); end
                  2'd1: m_cnt = int'(data[15:0]);
                  2'd2: m_hi = data;
                  default: begin
                     if (((m_page % 64) + m_cnt > 64) || full) nirq = 1'b1;
                     else begin
                        push = 1'b1;
                        nd = {m_dir, 24'(m_page), 16'(m_cnt), m_hi, data};
                     end
                  end
               endcase
               m_exp = (m_exp + 1) % 4;
            end else begin
               nirq = 1'b1; m_exp = 0;
            end
         end else if (mid) begin
            nirq = 1'b1; m_exp = 0;
         end else if (is_bad) begin
            nirq = 1'b1;
         end
      end
      if (desc_ready && m_q.size() != 0) void'(m_q.pop_front());
      if (dma_done && m_out > 0) m_out--;
      if (push) begin m_q.push_back(nd); m_out++; end
      m_irq = nirq;
      @(posedge clk);
      @(negedge clk);
      dma_done = 1'b0;
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) cyc(1'b0, 2'b00, 2'b00, 2'd0, 32'h0, tag);
   endtask

   task automatic dma4(input bit dir, input int page, input int cnt,
                       input logic [63:0] addr, input string tag);
      cyc(1'b1, 2'b10, 2'b00, 2'd0, {dir, 7'h0, 24'(page)}, tag);
      cyc(1'b1, 2'b10, 2'b00, 2'd1, {16'hA5A5, 16'(cnt)}, tag);
      cyc(1'b1, 2'b10, 2'b00, 2'd2, addr[63:32], tag);
      cyc(1'b1, 2'b10, 2'b00, 2'd3, addr[31:0], tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL R11 watchdog actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      // R11: start-up reset
      repeat (2) @(negedge clk);
      #1;
      chk(unsup_irq == 1'b0, "R11", "irq in reset", unsup_irq, 0);
      chk(desc_valid == 1'b0, "R11", "desc_valid in reset", desc_valid, 0);
      chk(fwd_valid == 1'b0, "R11", "fwd_valid in reset", fwd_valid, 0);
      @(negedge clk);
      rst_n = 1'b1;
      model_reset();
      idle(2, "R11");

      // R1 and R10: normal mode forwarding with back-pressure
      dma_en = 1'b0;
      cyc(1'b1, 2'b00, 2'b01, 2'd0, 32'h1111_0000, "R1");
      cyc(1'b1, 2'b01, 2'b10, 2'd0, 32'h2222_0001, "R1");
      fwd_ready = 1'b0;
      cyc(1'b1, 2'b11, 2'b11, 2'd0, 32'h3333_0002, "R10");
      cyc(1'b1, 2'b11, 2'b11, 2'd0, 32'h3333_0002, "R10");
      fwd_ready = 1'b1;
      cyc(1'b1, 2'b11, 2'b11, 2'd0, 32'h3333_0002, "R1");
      cyc(1'b1, 2'b10, 2'b00, 2'd0, 32'h0000_0005, "R1");
      idle(1, "R9");

      // R3: maintenance and pipeline ops under both modes
      cyc(1'b1, 2'b10, 2'b10, 2'd0, 32'hE4A5_0000, "R3");
      cyc(1'b1, 2'b10, 2'b01, 2'd0, 32'hB0B0_0000, "R3");
      dma_en = 1'b1;
      cyc(1'b1, 2'b10, 2'b11, 2'd0, 32'hC0C0_0001, "R3");
      cyc(1'b1, 2'b10, 2'b01, 2'd0, 32'hB0B0_0001, "R3");

      // R2: plain MAP classes refused while DMA is on
      cyc(1'b1, 2'b00, 2'b00, 2'd0, 32'h0, "R2");
      cyc(1'b1, 2'b01, 2'b00, 2'd0, 32'h1, "R2");
      cyc(1'b1, 2'b11, 2'b00, 2'd0, 32'h2, "R2");
      idle(2, "R9");

      // R4 and R12: descriptors held, then drained in order
      desc_ready = 1'b0;
      dma4(1'b1, 5, 3, 64'h0000_0012_3456_7000, "R4");
      dma4(1'b0, 200, 7, 64'hFFFF_0000_8000_1000, "R12");
      idle(3, "R12");
      desc_ready = 1'b1;
      idle(3, "R12");
      dma_done = 1'b1; idle(1, "R8");
      dma_done = 1'b1; idle(1, "R8");

      // R5: index out of order
      cyc(1'b1, 2'b10, 2'b00, 2'd0, 32'h0000_0010, "R5");
      cyc(1'b1, 2'b10, 2'b00, 2'd2, 32'hDEAD_BEEF, "R5");
      cyc(1'b1, 2'b10, 2'b00, 2'd1, 32'h0000_0002, "R5");
      cyc(1'b1, 2'b10, 2'b00, 2'd0, 32'h0000_0011, "R5");
      cyc(1'b1, 2'b10, 2'b00, 2'd0, 32'h0000_0012, "R5");
      idle(1, "R5");
      dma4(1'b1, 9, 1, 64'h0000_0001_0000_2000, "R5");
      idle(2, "R5");

      // R6: interleaved commands
      cyc(1'b1, 2'b10, 2'b00, 2'd0, 32'h0000_0020, "R6");
      cyc(1'b1, 2'b10, 2'b00, 2'd1, 32'h0000_0004, "R6");
      cyc(1'b1, 2'b10, 2'b10, 2'd0, 32'hE4A5_1111, "R6");
      cyc(1'b1, 2'b10, 2'b10, 2'd0, 32'hE4A5_2222, "R6");
      cyc(1'b1, 2'b10, 2'b00, 2'd0, 32'h0000_0030, "R6");
      cyc(1'b1, 2'b00, 2'b00, 2'd0, 32'h0, "R6");
      cyc(1'b1, 2'b10, 2'b00, 2'd2, 32'h0, "R6");
      idle(1, "R6");

      // R7: block boundary (64 pages per block)
      dma_done = 1'b1; idle(1, "R8");
      dma_done = 1'b1; idle(1, "R8");
      dma4(1'b0, 60, 4, 64'h0000_0000_0001_0000, "R7");
      dma4(1'b0, 60, 5, 64'h0000_0000_0002_0000, "R7");
      dma4(1'b1, 128 + 63, 1, 64'h0000_0000_0003_0000, "R7");
      dma4(1'b1, 128 + 63, 2, 64'h0000_0000_0004_0000, "R7");
      dma4(1'b1, 64, 64, 64'h0000_0000_0005_0000, "R7");
      idle(2, "R7");

      // R8: drain, saturate at zero, fill, refuse, free one
      for (int i = 0; i < 6; i++) begin dma_done = 1'b1; idle(1, "R8"); end
      desc_ready = 1'b0;
      for (int i = 0; i < 4; i++) dma4(i[0], 8 * i, 2, {32'h0, 32'(i)}, "R8");
      dma4(1'b1, 1, 1, 64'h0000_0000_0000_ABCD, "R8");
      desc_ready = 1'b1;
      idle(5, "R8");
      dma4(1'b1, 2, 1, 64'h0000_0000_0000_BCDE, "R8");
      dma_done = 1'b1; idle(1, "R8");
      dma4(1'b0, 3, 1, 64'h0000_0000_0000_CDEF, "R8");
      idle(3, "R8");

      // R11: reset in mid-run clears the open sequence and the count
      cyc(1'b1, 2'b10, 2'b00, 2'd0, 32'h0000_0040, "R11");
      cmd_valid = 1'b0;
      rst_n = 1'b0;
      #1;
      chk(desc_valid == 1'b0, "R11", "desc_valid after mid reset", desc_valid, 0);
      @(negedge clk);
      rst_n = 1'b1;
      model_reset();
      cyc(1'b1, 2'b10, 2'b00, 2'd1, 32'h0000_0001, "R11");
      idle(1, "R11");
      for (int i = 0; i < 4; i++) dma4(1'b0, 16 * i, 1, {32'h0, 32'(i)}, "R11");
      idle(6, "R11");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule